// File: doc/BRIEF.md
# Delta-Match Stride Prefetcher

This block watches the stream of demand-miss addresses coming out of a cache and proposes prefetch addresses. It keeps, for each requester, the two most recent miss block addresses. When a new miss arrives, it forms the delta from the last miss to the new one and the delta from the miss before that to the last one. When the two deltas are equal, the stride is taken to be confirmed, and the block emits up to `cfg_degree` candidate addresses that carry the stride forward. Each candidate carries a fixed delay value. A downstream prefetch queue takes these candidates.

Misses enter on a valid/ready port. A miss is taken only on a cycle where `miss_valid` and `miss_ready` are both high. `miss_ready` stays low for as long as candidates for the previous miss are still being emitted. Candidates leave on a second valid/ready port at one per cycle. While `pf_ready` is low, the current candidate and its delay are held unchanged. The configuration pins are plain levels. They are sampled at the moment a miss is accepted.

An optional page-stop mode stops the candidate run at the first address that falls outside the page of the miss. A running counter adds up how many candidates were dropped this way.

Top module: `stride_prefetcher`

## Requirements
- R1: A miss address is reduced to its block address by clearing its low `BLK_BITS` bits (6 by default), so every candidate has those bits at zero.
- R2: The new delta is block address minus last address, and the old delta is last address minus second-to-last address, both computed modulo 2^`ADDR_W`. A negative delta is therefore legal.
- R3: Every accepted miss shifts its history entry: the last address becomes the second-to-last, and the new block address becomes the last. All history entries reset to zero.
- R4: Candidates are produced only when the new delta equals the old delta. Candidate d, for d = 1 to `cfg_degree`, is the block address plus d times the delta. A degree of 0 produces nothing.
- R5: With `cfg_page_stop` high, the run ends before the first candidate whose page number differs from the miss's page number. The page number is address bits [`ADDR_W`-1:`PAGE_BITS`], with `PAGE_BITS` = 12 by default. With `cfg_page_stop` low, all candidates are emitted.
- R6: When the page check ends a run at candidate d, `span_count` increases by degree − d + 1.
- R7: `pf_delay` equals the value of `cfg_latency` at the cycle the miss was accepted, for every candidate of that miss.
- R8: With `cfg_per_req` high, history is selected by `miss_id`. With `cfg_per_req` low, every miss uses entry 0.
- R9: `pf_valid` is held high with `pf_addr` and `pf_delay` stable until `pf_ready` is high. With `pf_ready` held high, candidates come out on consecutive cycles.
- R10: `miss_ready` is low while a candidate run is in progress.
- R11: After reset, `pf_valid` is 0, `miss_ready` is 1 and `span_count` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_per_req | input | 1 | Selects history by requester ID when high |
| cfg_page_stop | input | 1 | Stops a run at a page crossing when high |
| cfg_degree | input | DEG_W | Maximum number of candidates per miss |
| cfg_latency | input | LAT_W | Delay value attached to each candidate |
| miss_valid | input | 1 | A miss is offered |
| miss_ready | output | 1 | The block can take a miss |
| miss_addr | input | ADDR_W | Miss byte address |
| miss_id | input | ID_W | Requester identifier |
| pf_valid | output | 1 | A candidate is offered |
| pf_ready | input | 1 | The downstream queue takes the candidate |
| pf_addr | output | ADDR_W | Candidate block address |
| pf_delay | output | LAT_W | Delay for the candidate |
| span_count | output | SPAN_W | Running total of candidates dropped at page crossings |

## Verification
The assertions assume that `pf_ready` is a free-running input. They also assume that `span_count` is never driven past its wrap point, since the monotonic check is suspended at all-ones. The stimulus lets `span_count` reach only a handful of counts. It offers misses only between runs, and it stalls `pf_ready` only inside one directed window. Configuration changes are made either while the block is idle or, in the stall window, after the miss has been accepted, which exercises the sampling rule.

// File: rtl/pf_pkg.sv
package pf_pkg;
  typedef enum logic {EM_IDLE = 1'b0, EM_RUN = 1'b1} emit_state_e;
endpackage

// File: rtl/pf_history.sv
module pf_history #(
  parameter int NUM_REQ = 64,
  parameter int ADDR_W  = 32,
  localparam int IDX_W  = $clog2(NUM_REQ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_last,
  output logic [ADDR_W-1:0] rd_prev,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_blk
);
  logic [ADDR_W-1:0] last_q [NUM_REQ];
  logic [ADDR_W-1:0] prev_q [NUM_REQ];

  assign rd_last = last_q[rd_idx];
  assign rd_prev = prev_q[rd_idx];

  // R3: shift history of the selected requester on each accepted miss
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REQ; i++) begin
        last_q[i] <= '0;
        prev_q[i] <= '0;
      end
    end else if (wr_en) begin
      prev_q[rd_idx] <= last_q[rd_idx];
      last_q[rd_idx] <= wr_blk;
    end
  end

  a_r3_history_shift: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (prev_q[$past(rd_idx)] == $past(rd_last)) &&
              (last_q[$past(rd_idx)] == $past(wr_blk)));
endmodule

// File: rtl/pf_emitter.sv
module pf_emitter
  import pf_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int DEG_W     = 3,
  parameter int LAT_W     = 8,
  localparam int PG_W     = ADDR_W - PAGE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] first_addr,
  input  logic [PG_W-1:0]   home_page,
  input  logic [ADDR_W-1:0] stride,
  input  logic [DEG_W-1:0]  degree,
  input  logic              page_stop,
  input  logic [LAT_W-1:0]  latency,
  output logic              busy,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr,
  output logic [LAT_W-1:0]  pf_delay,
  output logic              drop_pulse,
  output logic [DEG_W-1:0]  drop_amt
);
  emit_state_e       state_q;
  logic [ADDR_W-1:0] cur_q, stride_q, nxt;
  logic [PG_W-1:0]   page_q;
  logic [DEG_W-1:0]  deg_q, idx_q;
  logic              ps_q;
  logic [LAT_W-1:0]  lat_q;
  logic              fire, last_one, nxt_cross;

  assign busy      = (state_q == EM_RUN);
  assign pf_valid  = busy;
  assign pf_addr   = cur_q;
  assign pf_delay  = lat_q;
  assign fire      = pf_valid && pf_ready;
  assign nxt       = cur_q + stride_q;
  assign last_one  = (idx_q == deg_q);
  assign nxt_cross = ps_q && (nxt[ADDR_W-1:PAGE_BITS] != page_q);
  // R6: candidates idx+1..deg are dropped, i.e. deg - (idx+1) + 1
  assign drop_pulse = fire && !last_one && nxt_cross;
  assign drop_amt   = deg_q - idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= EM_IDLE;
      cur_q    <= '0;
      stride_q <= '0;
      page_q   <= '0;
      deg_q    <= '0;
      idx_q    <= '0;
      ps_q     <= 1'b0;
      lat_q    <= '0;
    end else if (state_q == EM_IDLE) begin
      if (start) begin
        state_q  <= EM_RUN;
        cur_q    <= first_addr;
        stride_q <= stride;
        page_q   <= home_page;
        deg_q    <= degree;
        idx_q    <= DEG_W'(1);
        ps_q     <= page_stop;
        lat_q    <= latency;
      end
    end else if (fire) begin
      if (last_one || nxt_cross) begin
        state_q <= EM_IDLE;
      end else begin
        cur_q <= nxt;
        idx_q <= idx_q + DEG_W'(1);
      end
    end
  end

  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready) |=> pf_valid && $stable(pf_addr) && $stable(pf_delay));
  a_r5_same_page: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && ps_q) |-> (pf_addr[ADDR_W-1:PAGE_BITS] == page_q));
  a_r4_index_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> (idx_q != '0) && (idx_q <= deg_q));
endmodule

// File: rtl/stride_prefetcher.sv
module stride_prefetcher #(
  parameter int ADDR_W    = 32,
  parameter int BLK_BITS  = 6,
  parameter int PAGE_BITS = 12,
  parameter int NUM_REQ   = 64,
  parameter int DEG_W     = 3,
  parameter int LAT_W     = 8,
  parameter int SPAN_W    = 16,
  localparam int ID_W     = $clog2(NUM_REQ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_per_req,
  input  logic              cfg_page_stop,
  input  logic [DEG_W-1:0]  cfg_degree,
  input  logic [LAT_W-1:0]  cfg_latency,
  input  logic              miss_valid,
  output logic              miss_ready,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic [ID_W-1:0]   miss_id,
  output logic              pf_valid,
  input  logic              pf_ready,
  output logic [ADDR_W-1:0] pf_addr,
  output logic [LAT_W-1:0]  pf_delay,
  output logic [SPAN_W-1:0] span_count
);
  localparam int PG_W = ADDR_W - PAGE_BITS;
  localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'((64'd1 << BLK_BITS) - 64'd1);

  logic [ID_W-1:0]   hist_idx;
  logic [ADDR_W-1:0] blk, last_a, prev_a, new_d, old_d, first_c;
  logic              accept, match, first_cross, start, emit_busy;
  logic              drop_pulse;
  logic [DEG_W-1:0]  drop_amt;
  logic [SPAN_W-1:0] span_q;

  // R1: block address, R8: history selection
  assign blk      = miss_addr & ~OFS_MASK;
  assign hist_idx = cfg_per_req ? miss_id : '0;
  assign accept   = miss_valid && miss_ready;
  assign miss_ready = !emit_busy;

  pf_history #(.NUM_REQ(NUM_REQ), .ADDR_W(ADDR_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .rd_idx(hist_idx),
    .rd_last(last_a), .rd_prev(prev_a),
    .wr_en(accept), .wr_blk(blk)
  );

  // R2, R4: delta compare and first candidate
  assign new_d       = blk - last_a;
  assign old_d       = last_a - prev_a;
  assign match       = (new_d == old_d) && (cfg_degree != '0);
  assign first_c     = blk + new_d;
  assign first_cross = cfg_page_stop &&
                       (first_c[ADDR_W-1:PAGE_BITS] != blk[ADDR_W-1:PAGE_BITS]);
  assign start       = accept && match && !first_cross;

  pf_emitter #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .DEG_W(DEG_W),
               .LAT_W(LAT_W)) u_emit (
    .clk(clk), .rst_n(rst_n), .start(start),
    .first_addr(first_c), .home_page(blk[ADDR_W-1:PAGE_BITS]),
    .stride(new_d), .degree(cfg_degree), .page_stop(cfg_page_stop),
    .latency(cfg_latency), .busy(emit_busy),
    .pf_valid(pf_valid), .pf_ready(pf_ready),
    .pf_addr(pf_addr), .pf_delay(pf_delay),
    .drop_pulse(drop_pulse), .drop_amt(drop_amt)
  );

  // R6: dropped-candidate total
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      span_q <= '0;
    end else if (accept && match && first_cross) begin
      span_q <= span_q + SPAN_W'(cfg_degree);
    end else if (drop_pulse) begin
      span_q <= span_q + SPAN_W'(drop_amt);
    end
  end
  assign span_count = span_q;

  a_r6_span_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(span_q) != '1) |-> (span_q >= $past(span_q)));
  a_r10_no_miss_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready) |=> !miss_ready);
  a_r1_block_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> ((pf_addr & OFS_MASK) == '0));

  localparam logic [PG_W-1:0] PG_ZERO = '0;
  initial assert (PG_W > 0 && PG_ZERO == '0);
endmodule

// File: tb/stride_prefetcher_test.sv
`timescale 1ns/1ps
module stride_prefetcher_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_per_req = 1'b1, cfg_page_stop = 1'b1;
  logic [2:0]  cfg_degree = 3'd3;
  logic [7:0]  cfg_latency = 8'd20;
  logic        miss_valid = 1'b0;
  logic        miss_ready;
  logic [31:0] miss_addr = '0;
  logic [5:0]  miss_id = '0;
  logic        pf_valid;
  logic        pf_ready = 1'b1;
  logic [31:0] pf_addr;
  logic [7:0]  pf_delay;
  logic [15:0] span_count;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  stride_prefetcher uut (
    .clk(clk), .rst_n(rst_n), .cfg_per_req(cfg_per_req),
    .cfg_page_stop(cfg_page_stop), .cfg_degree(cfg_degree),
    .cfg_latency(cfg_latency), .miss_valid(miss_valid),
    .miss_ready(miss_ready), .miss_addr(miss_addr), .miss_id(miss_id),
    .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr),
    .pf_delay(pf_delay), .span_count(span_count)
  );

  typedef struct packed {
    logic [5:0]  id;
    logic [31:0] addr;
    logic [2:0]  n;
    logic [31:0] first;
    logic [31:0] stride;
  } vec_t;

  // per-requester mode, page stop on, degree 3, latency 20
  localparam int NV = 15;
  localparam vec_t VEC [NV] = '{
    '{6'd1, 32'h0000_1000, 3'd0, 32'h0, 32'h0},
    '{6'd1, 32'h0000_1040, 3'd0, 32'h0, 32'h0},
    '{6'd1, 32'h0000_1085, 3'd3, 32'h0000_10C0, 32'h40},
    '{6'd2, 32'h0000_5F00, 3'd0, 32'h0, 32'h0},
    '{6'd2, 32'h0000_5F40, 3'd0, 32'h0, 32'h0},
    '{6'd2, 32'h0000_5F80, 3'd1, 32'h0000_5FC0, 32'h40},
    '{6'd1, 32'h0000_10C0, 3'd3, 32'h0000_1100, 32'h40},
    '{6'd1, 32'h0000_1100, 3'd3, 32'h0000_1140, 32'h40},
    '{6'd3, 32'h0000_3000, 3'd0, 32'h0, 32'h0},
    '{6'd3, 32'h0000_2FC0, 3'd0, 32'h0, 32'h0},
    '{6'd3, 32'h0000_2F80, 3'd3, 32'h0000_2F40, 32'hFFFF_FFC0},
    '{6'd3, 32'h0000_2FF0, 3'd0, 32'h0, 32'h0},
    '{6'd4, 32'h0000_7D00, 3'd0, 32'h0, 32'h0},
    '{6'd4, 32'h0000_7E00, 3'd0, 32'h0, 32'h0},
    '{6'd4, 32'h0000_7F00, 3'd0, 32'h0, 32'h0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic offer(input logic [5:0] id, input logic [31:0] addr);
    @(negedge clk);
    miss_valid = 1'b1; miss_id = id; miss_addr = addr;
    while (!miss_ready) @(negedge clk);
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  task automatic collect(input logic [2:0] n, input logic [31:0] first,
                         input logic [31:0] stride, input logic [7:0] lat);
    int cnt = 0;
    while (pf_valid && cnt < 16) begin
      chk(pf_addr == first + cnt * stride, "R4 candidate address", pf_addr,
          first + cnt * stride);
      chk(pf_addr[5:0] == 6'd0, "R1 block aligned", {26'd0, pf_addr[5:0]}, 32'd0);
      chk(pf_delay == lat, "R7 delay", {24'd0, pf_delay}, {24'd0, lat});
      cnt++;
      @(negedge clk);
    end
    chk(cnt == int'(n), "R9 candidate count", cnt, {29'd0, n});
  endtask

  task automatic run(input logic [5:0] id, input logic [31:0] addr,
                     input logic [2:0] n, input logic [31:0] first,
                     input logic [31:0] stride);
    offer(id, addr);
    collect(n, first, stride, cfg_latency);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(pf_valid == 1'b0, "R11 pf_valid", {31'd0, pf_valid}, 32'd0);
    chk(miss_ready == 1'b1, "R11 miss_ready", {31'd0, miss_ready}, 32'd1);
    chk(span_count == 16'd0, "R11 span_count", {16'd0, span_count}, 32'd0);

    // R2 R3 R5 R8: table walk
    for (int i = 0; i < NV; i++)
      run(VEC[i].id, VEC[i].addr, VEC[i].n, VEC[i].first, VEC[i].stride);
    chk(span_count == 16'd5, "R6 span after table", {16'd0, span_count}, 32'd5);

    // R8: shared history, entry 0
    cfg_per_req = 1'b0;
    run(6'd5, 32'h0000_9000, 3'd0, 32'h0, 32'h0);
    run(6'd6, 32'h0000_9080, 3'd0, 32'h0, 32'h0);
    run(6'd7, 32'h0000_9100, 3'd3, 32'h0000_9180, 32'h80);

    // R9 R10 R7: stall with latency changed after accept
    pf_ready = 1'b0;
    offer(6'd0, 32'h0000_9180);
    cfg_latency = 8'd99;
    for (int k = 0; k < 4; k++) begin
      chk(pf_valid == 1'b1, "R9 held valid", {31'd0, pf_valid}, 32'd1);
      chk(pf_addr == 32'h0000_9200, "R9 held addr", pf_addr, 32'h0000_9200);
      chk(miss_ready == 1'b0, "R10 miss_ready low", {31'd0, miss_ready}, 32'd0);
      @(negedge clk);
    end
    pf_ready = 1'b1;
    collect(3'd3, 32'h0000_9200, 32'h80, 8'd20);
    cfg_latency = 8'd20;

    // R5: page stop off lets a run cross pages
    cfg_page_stop = 1'b0;
    run(6'd0, 32'h0000_9F00, 3'd0, 32'h0, 32'h0);
    run(6'd0, 32'h0000_AC80, 3'd3, 32'h0000_BA00, 32'hD80);
    chk(span_count == 16'd5, "R5 no drops with stop off", {16'd0, span_count}, 32'd5);

    // R4: degree 1 and degree 0
    cfg_degree = 3'd1;
    run(6'd0, 32'h0000_BA00, 3'd1, 32'h0000_C780, 32'hD80);
    cfg_degree = 3'd0;
    run(6'd0, 32'h0000_C780, 3'd0, 32'h0, 32'h0);
    chk(span_count == 16'd5, "R4 degree zero no drop", {16'd0, span_count}, 32'd5);

    // R6: first candidate crosses with degree 1
    cfg_degree = 3'd1;
    cfg_page_stop = 1'b1;
    run(6'd0, 32'h0000_D500, 3'd0, 32'h0, 32'h0);
    chk(span_count == 16'd6, "R6 span after cross", {16'd0, span_count}, 32'd6);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule